// File: doc/BRIEF.md
# Timestamp Counter with One-Shot Alarm

This block keeps a free-running binary count that advances by one on every clock and wraps around at 2**WIDTH. Other logic reads the count directly for timestamps, and a snapshot strobe captures it into a holding register so that a later reading can be subtracted from it to give a latency.

One alarm comparator sits beside the counter. A schedule command loads a target and a compare mode (exact match or at-or-above threshold) and arms the alarm. While armed, the alarm fires exactly once, as a one-cycle pulse, and then disarms. A cancel command drops a pending alarm; a reschedule command swaps the target of a pending alarm without disarming it. A sticky flag records that the alarm has fired since it was last scheduled.

Top module: `tsa_timer`

## Requirements
- R1: `count_o` increases by exactly one each clock after reset and wraps from 2**WIDTH-1 to 0.
- R2: In exact mode (`ge_mode_i` = 0 at schedule), an armed alarm raises `alarm_o` for one cycle, in the cycle after the one where `count_o` equals the target.
- R3: Scheduling in a cycle where `count_o` already equals the target fires with no added wait: `alarm_o` is high in the very next cycle.
- R4: Scheduling an exact target that is below the current count fires only after the counter wraps and reaches the target again (target c-5 scheduled at count c fires 2**WIDTH-4 cycles later).
- R5: In threshold mode (`ge_mode_i` = 1) the alarm fires in the cycle after the first cycle in which `count_o` is greater than or equal to the target, immediately if that already holds at scheduling.
- R6: `cancel_i` on a pending alarm stops it from firing and clears `armed_o`; on a disarmed alarm it changes nothing.
- R7: `resched_i` on a pending alarm replaces target and mode and keeps it armed; it is ignored while disarmed, and `cancel_i` in the same cycle beats it.
- R8: `fired_o` goes high together with `alarm_o` and stays high until the next schedule command, which clears it.
- R9: `snap_i` copies the current `count_o` into `snap_o`, visible in the next cycle and held until the next strobe.
- R10: The alarm is one-shot: after firing `armed_o` is 0 and no later match fires it; `sched_i` wins over `cancel_i` and `resched_i` in the same cycle.
- R11: Synchronous active-low reset clears the count, the snapshot, the armed state, the alarm pulse and the fired flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snap_i | input | 1 | Snapshot strobe |
| sched_i | input | 1 | Schedule: load target and mode, arm, clear fired flag |
| cancel_i | input | 1 | Drop a pending alarm |
| resched_i | input | 1 | Replace target and mode of a pending alarm |
| target_i | input | WIDTH | Target or threshold value for schedule/reschedule |
| ge_mode_i | input | 1 | 0 exact match, 1 at-or-above threshold |
| count_o | output | WIDTH | Running count |
| snap_o | output | WIDTH | Captured count |
| alarm_o | output | 1 | One-cycle alarm pulse |
| fired_o | output | 1 | Sticky fired flag |
| armed_o | output | 1 | Alarm is pending |

## Verification
The properties assume that commands are single-cycle strobes sampled at the clock edge and that the one-cycle pulse and sticky-flag claims apply only when no new schedule arrives in the firing cycle. The stimulus issues every command as a one-cycle pulse driven away from the edge and leaves idle cycles after each firing, except for the deliberate same-cycle combinations that exercise command priority. A small counter width lets the wrap and passed-target cases run in a few hundred cycles.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;
   typedef enum logic {
      CMP_EXACT = 1'b0,
      CMP_AT_OR_ABOVE = 1'b1
   } cmp_mode_e;

   typedef enum logic [1:0] {
      ACT_HOLD,
      ACT_LOAD,
      ACT_SWAP,
      ACT_DROP
   } alarm_act_e;
endpackage

// File: rtl/tsa_free_counter.sv
`timescale 1ns/1ps
module tsa_free_counter #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] count_o
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + STEP;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/tsa_snap_reg.sv
`timescale 1ns/1ps
module tsa_snap_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_i,
   input  logic [WIDTH-1:0] value_i,
   output logic [WIDTH-1:0] held_o
);
   logic [WIDTH-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        held_q <= '0;
      else if (strobe_i) held_q <= value_i;
   end

   assign held_o = held_q;
endmodule

// File: rtl/tsa_compare.sv
`timescale 1ns/1ps
module tsa_compare #(
   parameter int WIDTH    = 32,
   parameter bit GE_EN    = 1'b1
) (
   input  logic [WIDTH-1:0]   value_i,
   input  logic [WIDTH-1:0]   ref_i,
   input  tsa_pkg::cmp_mode_e mode_i,
   output logic               hit_o
);
   logic eq_w;
   assign eq_w = (value_i == ref_i);

   generate
      if (GE_EN) begin : g_ge
         logic ge_w;
         assign ge_w  = (value_i >= ref_i);
         assign hit_o = (mode_i == tsa_pkg::CMP_AT_OR_ABOVE) ? ge_w : eq_w;
      end else begin : g_eq_only
         tsa_pkg::cmp_mode_e unused_mode;
         assign unused_mode = mode_i;
         assign hit_o = eq_w;
      end
   endgenerate
endmodule

// File: rtl/tsa_alarm_ctrl.sv
`timescale 1ns/1ps
module tsa_alarm_ctrl #(
   parameter int WIDTH = 32,
   parameter bit GE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] count_i,
   input  logic             sched_i,
   input  logic             cancel_i,
   input  logic             resched_i,
   input  logic [WIDTH-1:0] target_i,
   input  logic             ge_mode_i,
   output logic             alarm_o,
   output logic             fired_o,
   output logic             armed_o
);
   import tsa_pkg::*;

   logic [WIDTH-1:0] tgt_q;
   cmp_mode_e        mode_q;
   logic             armed_q;
   logic             alarm_q;
   logic             fired_q;

   alarm_act_e       act_w;
   logic [WIDTH-1:0] cmp_tgt_w;
   cmp_mode_e        cmp_mode_w;
   cmp_mode_e        in_mode_w;
   logic             live_w;
   logic             hit_w;
   logic             match_w;

   assign in_mode_w = (GE_EN && ge_mode_i) ? CMP_AT_OR_ABOVE : CMP_EXACT;

   // command priority: schedule, then cancel, then reschedule
   always_comb begin
      if (sched_i)                 act_w = ACT_LOAD;
      else if (!armed_q)           act_w = ACT_HOLD;
      else if (cancel_i)           act_w = ACT_DROP;
      else if (resched_i)          act_w = ACT_SWAP;
      else                         act_w = ACT_HOLD;
   end

   always_comb begin
      cmp_tgt_w  = tgt_q;
      cmp_mode_w = mode_q;
      live_w     = armed_q;
      unique case (act_w)
         ACT_LOAD, ACT_SWAP: begin
            cmp_tgt_w  = target_i;
            cmp_mode_w = in_mode_w;
            live_w     = 1'b1;
         end
         ACT_DROP: live_w = 1'b0;
         default:  live_w = armed_q;
      endcase
   end

   tsa_compare #(
      .WIDTH (WIDTH),
      .GE_EN (GE_EN)
   ) u_cmp (
      .value_i (count_i),
      .ref_i   (cmp_tgt_w),
      .mode_i  (cmp_mode_w),
      .hit_o   (match_w)
   );

   assign hit_w = live_w & match_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         mode_q  <= CMP_EXACT;
         armed_q <= 1'b0;
         alarm_q <= 1'b0;
         fired_q <= 1'b0;
      end else begin
         tgt_q   <= cmp_tgt_w;
         mode_q  <= cmp_mode_w;
         armed_q <= live_w & ~hit_w;
         alarm_q <= hit_w;
         fired_q <= hit_w | (fired_q & ~sched_i);
      end
   end

   assign alarm_o = alarm_q;
   assign fired_o = fired_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/tsa_timer.sv
`timescale 1ns/1ps
module tsa_timer #(
   parameter int WIDTH = 32,
   parameter bit GE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_i,
   input  logic             sched_i,
   input  logic             cancel_i,
   input  logic             resched_i,
   input  logic [WIDTH-1:0] target_i,
   input  logic             ge_mode_i,
   output logic [WIDTH-1:0] count_o,
   output logic [WIDTH-1:0] snap_o,
   output logic             alarm_o,
   output logic             fired_o,
   output logic             armed_o
);
   initial begin
      assert (WIDTH >= 2 && WIDTH <= 64)
         else $error("tsa_timer: WIDTH must lie in 2..64");
   end

   logic [WIDTH-1:0] count_w;

   tsa_free_counter #(.WIDTH(WIDTH)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_o (count_w)
   );

   tsa_snap_reg #(.WIDTH(WIDTH)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (snap_i),
      .value_i  (count_w),
      .held_o   (snap_o)
   );

   tsa_alarm_ctrl #(.WIDTH(WIDTH), .GE_EN(GE_EN)) u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_i   (count_w),
      .sched_i   (sched_i),
      .cancel_i  (cancel_i),
      .resched_i (resched_i),
      .target_i  (target_i),
      .ge_mode_i (ge_mode_i),
      .alarm_o   (alarm_o),
      .fired_o   (fired_o),
      .armed_o   (armed_o)
   );

   assign count_o = count_w;
endmodule

// File: rtl/tsa_timer_checker.sv
`timescale 1ns/1ps
module tsa_timer_checker #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snap_i,
   input logic             sched_i,
   input logic             cancel_i,
   input logic [WIDTH-1:0] count_o,
   input logic [WIDTH-1:0] snap_o,
   input logic             alarm_o,
   input logic             fired_o,
   input logic             armed_o
);
   logic got_rst = 1'b0;
   logic hist_ok = 1'b0;

   always_ff @(posedge clk) begin
      got_rst <= got_rst | ~rst_n;
      hist_ok <= got_rst & rst_n;
   end

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      count_o == WIDTH'($past(count_o) + WIDTH'(1)));

   p_pulse_one_r2: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      (alarm_o && !sched_i) |=> !alarm_o);

   p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      (cancel_i && !sched_i) |=> (!alarm_o && !armed_o));

   p_fired_with_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      alarm_o |-> fired_o);

   p_fired_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      (fired_o && !sched_i) |=> fired_o);

   p_snap_load_r9: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      snap_i |=> (snap_o == $past(count_o)));

   p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      !snap_i |=> $stable(snap_o));

   p_one_shot_r10: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      alarm_o |-> !armed_o);

   p_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      (!armed_o && !sched_i) |=> !alarm_o);
endmodule

bind tsa_timer tsa_timer_checker #(.WIDTH(WIDTH)) u_tsa_timer_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .snap_i   (snap_i),
   .sched_i  (sched_i),
   .cancel_i (cancel_i),
   .count_o  (count_o),
   .snap_o   (snap_o),
   .alarm_o  (alarm_o),
   .fired_o  (fired_o),
   .armed_o  (armed_o)
);

// File: tb/tsa_timer_bench.sv
`timescale 1ns/1ps
module tsa_timer_bench;
   localparam int W    = 8;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         snap_i = 1'b0;
   logic         sched_i = 1'b0;
   logic         cancel_i = 1'b0;
   logic         resched_i = 1'b0;
   logic [W-1:0] target_i = '0;
   logic         ge_mode_i = 1'b0;
   logic [W-1:0] count_o;
   logic [W-1:0] snap_o;
   logic         alarm_o;
   logic         fired_o;
   logic         armed_o;

   int total = 0;
   int bad = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   // behavioural reference state
   int m_cnt = 0, m_snap = 0, m_tgt = 0;
   bit m_ge = 0, m_armed = 0, m_alarm = 0, m_fired = 0;

   always #4 clk = ~clk;

   tsa_timer #(.WIDTH(W), .GE_EN(1'b1)) u_tsa_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .snap_i    (snap_i),
      .sched_i   (sched_i),
      .cancel_i  (cancel_i),
      .resched_i (resched_i),
      .target_i  (target_i),
      .ge_mode_i (ge_mode_i),
      .count_o   (count_o),
      .snap_o    (snap_o),
      .alarm_o   (alarm_o),
      .fired_o   (fired_o),
      .armed_o   (armed_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_snap = 0; m_tgt = 0; m_ge = 0;
         m_armed = 0; m_alarm = 0; m_fired = 0;
      end else begin
         bit pending;
         bit fire;
         pending = 0;
         if (sched_i) begin
            m_tgt = int'(target_i); m_ge = ge_mode_i; pending = 1;
         end else if (m_armed && !cancel_i) begin
            pending = 1;
            if (resched_i) begin
               m_tgt = int'(target_i); m_ge = ge_mode_i;
            end
         end
         fire = pending && (m_ge ? (m_cnt >= m_tgt) : (m_cnt == m_tgt));
         m_alarm = fire;
         m_armed = pending && !fire;
         if (sched_i) m_fired = 0;
         if (fire) m_fired = 1;
         if (snap_i) m_snap = m_cnt;
         m_cnt = (m_cnt + 1) & MASK;
      end
      #1;
      if (model_on) begin
         chk(int'(count_o) == m_cnt, "R1 count", count_o, m_cnt);
         chk(int'(snap_o) == m_snap, "R9 snapshot", snap_o, m_snap);
         chk(alarm_o == m_alarm, "R2 alarm", alarm_o, m_alarm);
         chk(fired_o == m_fired, "R8 fired", fired_o, m_fired);
         chk(armed_o == m_armed, "R10 armed", armed_o, m_armed);
      end
   end

   task automatic issue(input bit sch, input bit can, input bit res,
                        input int tgt, input bit ge);
      sched_i = sch; cancel_i = can; resched_i = res;
      target_i = W'(tgt & MASK); ge_mode_i = ge;
      @(negedge clk);
      sched_i = 0; cancel_i = 0; resched_i = 0;
   endtask

   task automatic until_alarm(input int lim, output int n);
      n = 1;
      while (!alarm_o && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic quiet(input int cyc, output bit seen);
      seen = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (alarm_o) seen = 1;
      end
   endtask

   initial begin
      int n, c, s1;
      bit seen;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(count_o == 0 && snap_o == 0, "R11 reset count/snap", count_o, 0);
      chk(!alarm_o && !fired_o && !armed_o, "R11 reset flags",
          {alarm_o, fired_o, armed_o}, 0);
      model_on = 1;
      rst_n = 1;
      @(negedge clk);
      chk(count_o == 1, "R1 first step", count_o, 1);

      // R1 wrap
      while (count_o != W'(MASK)) @(negedge clk);
      @(negedge clk);
      chk(count_o == 0, "R1 wrap", count_o, 0);

      // R3 immediate match, R2 one-cycle pulse
      repeat (5) @(negedge clk);
      issue(1, 0, 0, int'(count_o), 0);
      chk(alarm_o && fired_o, "R3 immediate", alarm_o, 1);
      @(negedge clk);
      chk(!alarm_o && !armed_o, "R2 pulse width", alarm_o, 0);

      // R4 passed target waits through wrap
      c = int'(count_o);
      issue(1, 0, 0, c - 5, 0);
      chk(!fired_o, "R8 cleared by schedule", fired_o, 0);
      until_alarm(400, n);
      chk(n == (1 << W) - 4, "R4 wait through wrap", n, (1 << W) - 4);

      // R5 threshold above and below
      while (count_o != 20) @(negedge clk);
      issue(1, 0, 0, 30, 1);
      until_alarm(400, n);
      chk(n == 11, "R5 threshold reached", n, 11);
      repeat (3) @(negedge clk);
      issue(1, 0, 0, 5, 1);
      chk(alarm_o, "R5 threshold already met", alarm_o, 1);

      // R6 cancel a pending alarm
      repeat (2) @(negedge clk);
      issue(1, 0, 0, int'(count_o) + 20, 0);
      repeat (3) @(negedge clk);
      issue(0, 1, 0, 0, 0);
      chk(!armed_o, "R6 cancel disarms", armed_o, 0);
      quiet(300, seen);
      chk(!seen && !fired_o, "R6 cancelled never fires", seen, 0);

      // R7 reschedule, R10 one-shot
      c = int'(count_o);
      issue(1, 0, 0, c + 60, 0);
      @(negedge clk);
      issue(0, 0, 1, int'(count_o) + 10, 0);
      chk(armed_o, "R7 stays armed", armed_o, 1);
      until_alarm(400, n);
      chk(n == 11, "R7 new target", n, 11);
      quiet(100, seen);
      chk(!seen && !armed_o, "R10 one-shot", seen, 0);

      // R6 cancel while disarmed leaves fired flag
      issue(0, 1, 0, 0, 0);
      chk(fired_o, "R6 idle cancel no effect", fired_o, 1);

      // R7 reschedule while disarmed ignored
      issue(0, 0, 1, int'(count_o) + 3, 0);
      quiet(10, seen);
      chk(!seen && !armed_o, "R7 idle reschedule ignored", seen, 0);

      // R7 cancel beats reschedule
      issue(1, 0, 0, int'(count_o) + 100, 0);
      issue(0, 1, 1, int'(count_o) + 3, 0);
      quiet(10, seen);
      chk(!seen && !armed_o, "R7 cancel over reschedule", seen, 0);

      // R10 schedule beats cancel
      issue(1, 1, 0, int'(count_o) + 4, 0);
      until_alarm(50, n);
      chk(n == 5, "R10 schedule over cancel", n, 5);

      // R9 snapshot and latency difference
      c = int'(count_o);
      issue(0, 0, 0, 0, 0);
      snap_i = 1; @(negedge clk); snap_i = 0;
      s1 = int'(snap_o);
      chk(s1 == ((c + 1) & MASK), "R9 capture", s1, (c + 1) & MASK);
      repeat (37) @(negedge clk);
      snap_i = 1; @(negedge clk); snap_i = 0;
      chk(((int'(snap_o) - s1) & MASK) == 38, "R9 latency",
          (int'(snap_o) - s1) & MASK, 38);

      // R11 reset mid-run
      issue(1, 0, 0, int'(count_o) + 50, 0);
      rst_n = 0;
      @(negedge clk);
      chk(count_o == 0 && snap_o == 0 && !armed_o && !fired_o && !alarm_o,
          "R11 reset mid-run", count_o, 0);
      rst_n = 1;
      quiet(60, seen);
      chk(!seen, "R11 no alarm after reset", seen, 0);
      done = 1;
   end

   initial begin
      int k;
      k = 0;
      while (!done && k < 20000) begin
         @(negedge clk);
         k++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", k);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule